// File: doc/BRIEF.md
# MDIO Management Bus Master

This block drives the two-wire Ethernet management bus from a system clock. It produces the management clock (MDC) through a parameterised divider and handles the bidirectional data line as three separate signals: an output value, an output enable and a sampled input. The tristate pad itself sits outside the block. A client places one request at a time on the request inputs and pulses `start`. The block raises `busy`, shifts the frame out and in, and signals completion with a single-cycle `done`. On reads, `done` comes with the returned data and an error flag.

A request selects read or write and chooses between the two framing styles. In the short style (clause 22), one frame carries a 5-bit register number. In the extended style (clause 45), a 21-bit address is split across two frames. The master first sends an address frame that carries the 16 low address bits as payload. It then sends, with no idle gap, a read or write frame. Both frames place the 5-bit device number (address bits 20:16) in the register field.

On a read, the master checks that the PHY pulls the turnaround bit low. If the PHY does not, and the ignore mask does not excuse that PHY, the master clocks out a flush of further bits, then reports all-ones data and a turnaround error.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever `busy` is low, `mdc` is 0, `mdio_oe` is 0, `busy` is 0 and `done` is 0.
- R2: Every frame opens with 32 bits at value 1, driven by the master (`mdio_oe`=1).
- R3: While `busy` is high, `start` is ignored and the latched request does not change. The frame in flight continues unaltered.
- R4: A clause-22 frame sends start bits 0,1, then opcode 1,0 for a read or 0,1 for a write. It then sends the 5-bit PHY address and the 5-bit register number (`reg_addr[4:0]`). Each field goes out MSB first.
- R5: On a write frame or an address frame, the master drives turnaround 1 then 0. It then drives 16 payload bits MSB first, and finally gives one clock with `mdio_oe`=0.
- R6: On a read frame, `mdio_oe` is 0 from the turnaround bit onward. If `mdio_i` is 0 at the end of the turnaround bit, the master takes 16 data bits MSB first, then gives one more released clock. It returns the data on `rd_data` with `ta_error`=0.
- R7: If the read turnaround bit is 1 and `ta_ignore_mask[phy_addr]` is 0, the master gives 32 more released clocks and ends with `rd_data`=16'hFFFF and `ta_error`=1. If that mask bit is 1, the read proceeds as in R6.
- R8: Each bit lasts `LOW_CYC` system cycles with `mdc` low, then `HIGH_CYC` cycles with `mdc` high on a driven bit, or `HIGH_RD_CYC` cycles on a released bit. `mdio_o` and `mdio_oe` change only at the start of a bit's low phase. The input is sampled on the last high cycle.
- R9: A clause-45 request sends an address frame first. That frame has start 0,0, opcode 0,0, the device field `reg_addr[20:16]` and the payload `reg_addr[15:0]`. It is followed at once by a second frame with start 0,0, opcode 1,1 for a read or 0,1 for a write, and the same device field.
- R10: `done` is a one-cycle pulse in the cycle after the final bit's high phase ends. `busy` falls in that same cycle. A write reports `rd_data`=0 and `ta_error`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when not busy |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| c45 | input | 1 | 1 = extended (two-frame) access |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 21 | Register number [4:0], or device [20:16] plus address [15:0] |
| wr_data | input | 16 | Write payload |
| ta_ignore_mask | input | 32 | Per-PHY turnaround-check bypass, bit index = PHY address |
| mdio_i | input | 1 | Sampled data line |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |
| ta_error | output | 1 | Read turnaround missing |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
The first bit's low phase begins on the clock edge that accepts `start`. `mdc` then rises `LOW_CYC` edges later and falls `HIGH_CYC` or `HIGH_RD_CYC` edges after that. The next bit's line values appear on that same falling edge. `done`, `rd_data` and `ta_error` appear right after the edge that ends the final high phase. The bench keeps its own bit list and edge counters, which advance on each rising edge. It compares every output against them at each falling edge, so each result is checked in exactly the cycle it is due. The PHY's replies on `mdio_i` are placed from the same list.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    FK_C22_RD,
    FK_C22_WR,
    FK_C45_ADR,
    FK_C45_RD,
    FK_C45_WR
  } frame_kind_e;

  typedef enum logic [3:0] {
    SG_IDLE,
    SG_PRE,
    SG_HDR,
    SG_TAW,
    SG_WDAT,
    SG_TAR,
    SG_RDAT,
    SG_FLUSH,
    SG_TAIL
  } seg_e;

  // start code (2 bits) followed by opcode (2 bits), first-sent bit at MSB
  function automatic logic [3:0] start_op(frame_kind_e k);
    case (k)
      FK_C22_RD:  return 4'b0110;
      FK_C22_WR:  return 4'b0101;
      FK_C45_ADR: return 4'b0000;
      FK_C45_RD:  return 4'b0011;
      default:    return 4'b0001;
    endcase
  endfunction

  function automatic logic [13:0] header_word(frame_kind_e k, logic [4:0] phy,
                                              logic [4:0] fld);
    return {start_op(k), phy, fld};
  endfunction

  function automatic logic is_read_kind(frame_kind_e k);
    return (k == FK_C22_RD) || (k == FK_C45_RD);
  endfunction

  function automatic logic ta_ignored(logic [31:0] mask, logic [4:0] phy);
    return mask[phy];
  endfunction

endpackage

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
  parameter int LOW_CYC     = 20,
  parameter int HIGH_CYC    = 20,
  parameter int HIGH_RD_CYC = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_hi,
  output logic mdc,
  output logic bit_end
);
  localparam int MAXC0 = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAXC  = (MAXC0 > HIGH_RD_CYC) ? MAXC0 : HIGH_RD_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LAST_LO  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] LAST_HI  = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] LAST_HRD = CW'(HIGH_RD_CYC - 1);

  logic [CW-1:0] cnt;
  logic          hi_q;
  logic [CW-1:0] last_cnt;
  logic          at_last;

  assign last_cnt = hi_q ? (long_hi ? LAST_HRD : LAST_HI) : LAST_LO;
  assign at_last  = (cnt == last_cnt);
  assign bit_end  = run & hi_q & at_last;
  assign mdc      = hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      hi_q <= 1'b0;
    end else if (at_last) begin
      cnt  <= '0;
      hi_q <= ~hi_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: the clock is only ever high while the frame engine is running
  a_r8_high_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q |-> run);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_BITS   = 32,
  parameter int FLUSH_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  frame_kind_e go_kind,
  input  logic [4:0]  go_phy,
  input  logic [4:0]  go_fld,
  input  logic [15:0] go_payload,
  input  logic [31:0] ta_mask,
  input  logic        mdio_i,
  input  logic        bit_end,
  output logic        run,
  output logic        long_hi,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        frame_end,
  output logic [15:0] rd_word,
  output logic        ta_err
);
  localparam int MAXB0 = (PRE_BITS > FLUSH_BITS) ? PRE_BITS : FLUSH_BITS;
  localparam int MAXB  = (MAXB0 > 16) ? MAXB0 : 16;
  localparam int LW    = $clog2(MAXB);

  seg_e        seg;
  logic [LW-1:0] left;
  logic [15:0] txsh;
  logic [15:0] rxsh;
  logic [15:0] pay_q;
  logic [4:0]  phy_q;
  frame_kind_e kind_q;
  logic        ta_err_q;
  logic        last;

  assign last      = (left == '0);
  assign run       = (seg != SG_IDLE);
  assign long_hi   = (seg == SG_TAR) || (seg == SG_RDAT) ||
                     (seg == SG_FLUSH) || (seg == SG_TAIL);
  assign frame_end = bit_end & ((seg == SG_TAIL) || ((seg == SG_FLUSH) && last));
  assign rd_word   = rxsh;
  assign ta_err    = ta_err_q;

  always_comb begin
    mdio_oe = 1'b0;
    mdio_o  = 1'b0;
    case (seg)
      SG_PRE:          begin mdio_oe = 1'b1; mdio_o = 1'b1;        end
      SG_HDR, SG_WDAT: begin mdio_oe = 1'b1; mdio_o = txsh[15];    end
      SG_TAW:          begin mdio_oe = 1'b1; mdio_o = (left != '0); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg      <= SG_IDLE;
      left     <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      pay_q    <= '0;
      phy_q    <= '0;
      kind_q   <= FK_C22_RD;
      ta_err_q <= 1'b0;
    end else if (go) begin
      seg      <= SG_PRE;
      left     <= LW'(PRE_BITS - 1);
      txsh     <= {header_word(go_kind, go_phy, go_fld), 2'b00};
      pay_q    <= go_payload;
      phy_q    <= go_phy;
      kind_q   <= go_kind;
      ta_err_q <= 1'b0;
    end else if (bit_end) begin
      case (seg)
        SG_PRE: begin
          if (last) begin seg <= SG_HDR; left <= LW'(13); end
          else left <= left - 1'b1;
        end
        SG_HDR: begin
          txsh <= txsh << 1;
          if (last) begin
            if (is_read_kind(kind_q)) begin
              seg  <= SG_TAR;
              left <= '0;
            end else begin
              seg  <= SG_TAW;
              left <= LW'(1);
              txsh <= pay_q;
            end
          end else left <= left - 1'b1;
        end
        SG_TAW: begin
          if (last) begin seg <= SG_WDAT; left <= LW'(15); end
          else left <= left - 1'b1;
        end
        SG_WDAT: begin
          txsh <= txsh << 1;
          if (last) begin seg <= SG_TAIL; left <= '0; end
          else left <= left - 1'b1;
        end
        SG_TAR: begin
          if (mdio_i && !ta_ignored(ta_mask, phy_q)) begin
            seg      <= SG_FLUSH;
            left     <= LW'(FLUSH_BITS - 1);
            ta_err_q <= 1'b1;
            rxsh     <= '1;
          end else begin
            seg  <= SG_RDAT;
            left <= LW'(15);
          end
        end
        SG_RDAT: begin
          rxsh <= {rxsh[14:0], mdio_i};
          if (last) begin seg <= SG_TAIL; left <= '0; end
          else left <= left - 1'b1;
        end
        SG_FLUSH: begin
          if (last) seg <= SG_IDLE;
          else left <= left - 1'b1;
        end
        default: seg <= SG_IDLE;
      endcase
    end
  end

  // R7: a frame that ends with a turnaround error always carries all-ones data
  a_r7_flush_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ta_err_q) |-> (rxsh == 16'hFFFF));

  // R6: the line is released for every receive-timed bit
  a_r6_released_when_long: assert property (@(posedge clk) disable iff (!rst_n)
    long_hi |-> !mdio_oe);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int LOW_CYC     = 20,
  parameter int HIGH_CYC    = 20,
  parameter int HIGH_RD_CYC = 35,
  parameter int PRE_BITS    = 32,
  parameter int FLUSH_BITS  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_nwr,
  input  logic        c45,
  input  logic [4:0]  phy_addr,
  input  logic [20:0] reg_addr,
  input  logic [15:0] wr_data,
  input  logic [31:0] ta_ignore_mask,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        ta_error,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic        busy_q, done_q, rd_q, c45_q, second_q, err_q;
  logic [4:0]  phy_q, dev_q;
  logic [15:0] wd_q, rdat_q;

  logic        accept, chain, finish, go;
  frame_kind_e go_kind;
  logic [4:0]  go_phy, go_fld;
  logic [15:0] go_payload;

  logic        run, long_hi, bit_end, frame_end, eng_err;
  logic [15:0] eng_word;

  assign accept = start & ~busy_q;
  assign chain  = frame_end & c45_q & ~second_q;
  assign finish = frame_end & ~chain;
  assign go     = accept | chain;

  always_comb begin
    if (accept) begin
      go_kind    = c45 ? FK_C45_ADR : (rd_nwr ? FK_C22_RD : FK_C22_WR);
      go_phy     = phy_addr;
      go_fld     = c45 ? reg_addr[20:16] : reg_addr[4:0];
      go_payload = c45 ? reg_addr[15:0] : wr_data;
    end else begin
      go_kind    = rd_q ? FK_C45_RD : FK_C45_WR;
      go_phy     = phy_q;
      go_fld     = dev_q;
      go_payload = wd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rd_q     <= 1'b0;
      c45_q    <= 1'b0;
      second_q <= 1'b0;
      err_q    <= 1'b0;
      phy_q    <= '0;
      dev_q    <= '0;
      wd_q     <= '0;
      rdat_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        rd_q     <= rd_nwr;
        c45_q    <= c45;
        second_q <= 1'b0;
        phy_q    <= phy_addr;
        dev_q    <= reg_addr[20:16];
        wd_q     <= wr_data;
      end else if (chain) begin
        second_q <= 1'b1;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        rdat_q <= rd_q ? eng_word : 16'h0000;
        err_q  <= rd_q & eng_err;
      end
    end
  end

  mdio_mdc_timer #(
    .LOW_CYC    (LOW_CYC),
    .HIGH_CYC   (HIGH_CYC),
    .HIGH_RD_CYC(HIGH_RD_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .long_hi(long_hi),
    .mdc    (mdc),
    .bit_end(bit_end)
  );

  mdio_frame_engine #(
    .PRE_BITS  (PRE_BITS),
    .FLUSH_BITS(FLUSH_BITS)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_kind   (go_kind),
    .go_phy    (go_phy),
    .go_fld    (go_fld),
    .go_payload(go_payload),
    .ta_mask   (ta_ignore_mask),
    .mdio_i    (mdio_i),
    .bit_end   (bit_end),
    .run       (run),
    .long_hi   (long_hi),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .frame_end (frame_end),
    .rd_word   (eng_word),
    .ta_err    (eng_err)
  );

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_data  = rdat_q;
  assign ta_error = err_q;

  // R1: idle bus while no request is in progress
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

  // R10: completion strobe lasts exactly one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3: latched request holds for the whole transaction
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(phy_q) && $stable(rd_q) && $stable(c45_q)
                                   && $stable(dev_q) && $stable(wd_q)));

  // R8: line value and enable stay put while the clock is high
  a_r8_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int LOW = 20;
  localparam int HI  = 20;
  localparam int HRD = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_nwr = 1'b0;
  logic        c45 = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [20:0] reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] ta_ignore_mask = '0;
  logic        mdio_i = 1'b1;
  wire         busy, done, ta_error, mdc, mdio_o, mdio_oe;
  wire  [15:0] rd_data;

  always #5 clk = ~clk;

  mdio_master #(.LOW_CYC(LOW), .HIGH_CYC(HI), .HIGH_RD_CYC(HRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .c45(c45),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .ta_ignore_mask(ta_ignore_mask), .mdio_i(mdio_i), .busy(busy), .done(done),
    .rd_data(rd_data), .ta_error(ta_error), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe));

  // expected bit list: driven value, enable, long high phase, PHY reply, tag
  bit    q_drv[$];
  bit    q_oe[$];
  bit    q_lng[$];
  bit    q_phy[$];
  string q_tag[$];

  int    nvec = 0, nfail = 0;
  bit    m_act = 0, m_hi = 0, m_done = 0;
  int    m_i = 0, m_c = 0;
  logic [15:0] exp_rd = '0;
  logic        exp_err = 1'b0;
  string       done_tag = "R10";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // reference timing model, advanced on each rising edge
  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      m_act = 0; m_hi = 0; m_c = 0; m_i = 0;
    end else if (m_act) begin
      m_c++;
      if (!m_hi) begin
        if (m_c == LOW) begin m_hi = 1; m_c = 0; end
      end else if (m_c == (q_lng[m_i] ? HRD : HI)) begin
        m_hi = 0; m_c = 0; m_i++;
        if (m_i == q_drv.size()) begin m_act = 0; m_done = 1; end
      end
    end else if (start) begin
      m_act = 1; m_i = 0; m_hi = 0; m_c = 0;
    end
  end

  // compare on every falling edge, then place the PHY's reply
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_act) begin
        chk({"R8 mdc ", q_tag[m_i]}, {31'b0, mdc}, {31'b0, m_hi});
        chk({q_tag[m_i], " mdio_oe"}, {31'b0, mdio_oe}, {31'b0, q_oe[m_i]});
        if (q_oe[m_i]) chk({q_tag[m_i], " mdio_o"}, {31'b0, mdio_o}, {31'b0, q_drv[m_i]});
        chk("R3 busy", {31'b0, busy}, 32'd1);
      end else begin
        chk("R1 idle mdc", {31'b0, mdc}, 32'd0);
        chk("R1 idle mdio_oe", {31'b0, mdio_oe}, 32'd0);
        chk("R10 busy low", {31'b0, busy}, 32'd0);
      end
      chk("R10 done", {31'b0, done}, {31'b0, m_done});
      if (m_done) begin
        chk({done_tag, " rd_data"}, {16'b0, rd_data}, {16'b0, exp_rd});
        chk({done_tag, " ta_error"}, {31'b0, ta_error}, {31'b0, exp_err});
      end
      mdio_i = (m_act && !q_oe[m_i]) ? q_phy[m_i] : 1'b1;
    end
  end

  task automatic push_bit(bit drv, bit oe, bit lng, bit phy, string tag);
    q_drv.push_back(drv); q_oe.push_back(oe); q_lng.push_back(lng);
    q_phy.push_back(phy); q_tag.push_back(tag);
  endtask

  task automatic push_hdr(bit [1:0] st, bit [1:0] op, int phy, int fld, string tag);
    for (int k = 0; k < 32; k++) push_bit(1, 1, 0, 1, "R2");
    push_bit(st[1], 1, 0, 1, tag); push_bit(st[0], 1, 0, 1, tag);
    push_bit(op[1], 1, 0, 1, tag); push_bit(op[0], 1, 0, 1, tag);
    for (int k = 4; k >= 0; k--) push_bit(phy[k], 1, 0, 1, tag);
    for (int k = 4; k >= 0; k--) push_bit(fld[k], 1, 0, 1, tag);
  endtask

  task automatic push_wtail(int payload, string tag);
    push_bit(1, 1, 0, 1, "R5");
    push_bit(0, 1, 0, 1, "R5");
    for (int k = 15; k >= 0; k--) push_bit(payload[k], 1, 0, 1, tag);
    push_bit(0, 0, 1, 1, "R5");
  endtask

  task automatic push_rtail(bit ta_ok, bit masked, int data);
    push_bit(0, 0, 1, !ta_ok, "R6");
    if (ta_ok || masked) begin
      for (int k = 15; k >= 0; k--) push_bit(0, 0, 1, data[k], "R6");
      push_bit(0, 0, 1, 1, "R6");
    end else begin
      for (int k = 0; k < 32; k++) push_bit(0, 0, 1, 1, "R7");
    end
  endtask

  task automatic run_txn(bit rd, bit ext, int phy, int addr, int wd, int mask,
                         bit ta_ok, int phy_data, bit poke);
    bit masked;
    masked = mask[phy];
    q_drv.delete(); q_oe.delete(); q_lng.delete(); q_phy.delete(); q_tag.delete();
    if (ext) begin
      push_hdr(2'b00, 2'b00, phy, (addr >> 16) & 31, "R9");
      push_wtail(addr & 16'hFFFF, "R9");
      push_hdr(2'b00, rd ? 2'b11 : 2'b01, phy, (addr >> 16) & 31, "R9");
    end else begin
      push_hdr(2'b01, rd ? 2'b10 : 2'b01, phy, addr & 31, "R4");
    end
    if (rd) push_rtail(ta_ok, masked, phy_data);
    else    push_wtail(wd, "R5");
    exp_rd   = !rd ? 16'h0000 : ((ta_ok || masked) ? 16'(phy_data) : 16'hFFFF);
    exp_err  = rd && !ta_ok && !masked;
    done_tag = !rd ? "R10" : (exp_err ? "R7" : "R6");
    @(negedge clk);
    rd_nwr = rd; c45 = ext; phy_addr = 5'(phy); reg_addr = 21'(addr);
    wr_data = 16'(wd); ta_ignore_mask = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (200) @(negedge clk);
      // R3: a second request while busy must leave the frame untouched
      rd_nwr = ~rd; c45 = ~ext; phy_addr = ~5'(phy); reg_addr = ~21'(addr);
      wr_data = ~16'(wd); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_act) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    #(190000 * 10);
    nfail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mdc", {31'b0, mdc}, 32'd0);
    chk("R1 reset mdio_oe", {31'b0, mdio_oe}, 32'd0);
    chk("R1 reset busy", {31'b0, busy}, 32'd0);
    chk("R1 reset done", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // clause-22 write (R4, R5)
    run_txn(0, 0, 5'h13, 21'h0000A, 16'hA55A, 0, 1, 0, 0);
    // clause-22 read, good turnaround, start poked while busy (R6, R3)
    run_txn(1, 0, 5'h01, 21'h00002, 0, 0, 1, 16'h1234, 1);
    // missing turnaround, not masked (R7)
    run_txn(1, 0, 5'h07, 21'h0001F, 0, 32'h0000_0000, 0, 0, 0);
    // missing turnaround, masked for this PHY (R7)
    run_txn(1, 0, 5'h07, 21'h00011, 0, 32'h0000_0080, 0, 16'hBEEF, 0);
    // clause-45 write (R9, R5)
    run_txn(0, 1, 5'h03, 21'h1F8001, 16'h0F0F, 0, 1, 0, 1);
    // clause-45 read (R9, R6)
    run_txn(1, 1, 5'h1F, 21'h05C3A5, 0, 0, 1, 16'h8001, 0);
    // clause-45 read, missing turnaround, other PHYs masked (R7)
    run_txn(1, 1, 5'h02, 21'h0A0000, 0, 32'hFFFF_FFFB, 0, 0, 0);
    report();
    $finish;
  end

endmodule